// File: doc/BRIEF.md
# Descriptor Chain Transmit DMA

This engine drains a chain of packet buffer descriptors from memory into a byte-wide packet stream. A host starts it by writing the address of the first descriptor. For each descriptor, the engine reads four 32-bit words. It then streams the described buffer one byte per accepted handshake and writes the flags word back with its ownership bit cleared. After that it moves on to the descriptor named by the link word. The chain ends after the engine handles a descriptor whose link word is zero.

At the end of a chain the engine records the address of the final descriptor in a completion register and raises an interrupt. The host acknowledges the interrupt by writing that same address back. Two sticky flags report problems. One marks a start request that arrived while the engine was busy. The other marks a chain whose final descriptor did not close a packet.

Memory is a single word port with combinational read data. Reads and write-backs use byte addresses that are aligned to a word.

Top module: `desc_chain_dma`

## Requirements
- R1: After reset, `busy`, `irq`, `overrun`, `no_eop_err`, `tx_valid`, `mem_rd` and `mem_wr` are low, and `done_addr` is zero.
- R2: A head write (`reg_wr`=1, `reg_sel`=0) while idle starts the engine. Starting in the next cycle, it reads the descriptor words at head+0, head+4, head+8 and head+12, one per cycle, with `mem_rd` high.
- R3: Descriptor layout. Word 0 is the link address. Word 1 is the buffer address. Word 2 holds the byte offset in [31:16] and the byte count in [15:0]. Word 3 holds flags in [31:16] and the packet length in [15:0]. Bit 31 marks start of packet, bit 30 marks end of packet and bit 29 is the ownership bit.
- R4: The bytes stream from address buffer+offset for count bytes, in ascending order. Byte lane k of a word is bits [8k+7:8k]. A byte stays on `tx_data` with `tx_valid` high until `tx_ready` is sampled high.
- R5: `tx_sop` is high on the first byte of a descriptor with bit 31 set. `tx_eop` is high on the last byte of a descriptor with bit 30 set. `tx_pkt_len` shows the packet length of the most recent descriptor with bit 31 set.
- R6: After a descriptor whose link word is nonzero, the engine fetches the descriptor at that link address. After a descriptor whose link word is zero, it stops.
- R7: After its bytes, each descriptor gets a one-cycle write of word 3 at descriptor+12, with bit 29 cleared and all other bits unchanged.
- R8: In the cycle after the final write-back, `busy` is low, `irq` is high and `done_addr` holds the final descriptor's address.
- R9: `irq` stays high until a completion write (`reg_wr`=1, `reg_sel`=1) whose data equals `done_addr`. A completion write with any other value has no effect.
- R10: A head write while `busy` is high is ignored and sets the sticky `overrun`. This includes a head write in the final write-back cycle.
- R11: `no_eop_err` is set at chain completion when the final descriptor lacks bit 30. It is cleared when the next head write is accepted.
- R12: A descriptor with a byte count of zero produces no bytes. Its write-back follows its flags read directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 1 | 0 = head register, 1 = completion register |
| reg_wdata | input | 32 | Host write data |
| busy | output | 1 | Chain in progress |
| irq | output | 1 | Chain complete interrupt |
| done_addr | output | AW | Address of last completed descriptor |
| overrun | output | 1 | Sticky: head write while busy |
| no_eop_err | output | 1 | Last chain ended without end of packet |
| mem_addr | output | AW | Memory byte address |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, same cycle |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Byte accepted |
| tx_data | output | 8 | Packet byte |
| tx_sop | output | 1 | First byte of packet |
| tx_eop | output | 1 | Last byte of packet |
| tx_pkt_len | output | 16 | Packet length from start descriptor |

## Verification
Two events can land in the same cycle: a new head write and the final write-back of the current chain. In that cycle `busy` is still high, so the request must be dropped and counted as an overrun, and the engine must not begin a second chain. The bench provokes this collision by watching its own event queue and issuing the head write exactly when the final write-back event is due. It then expects an idle engine, a raised interrupt and a set `overrun`, and it checks every port against a behavioural queue model on each clock, with `tx_ready` stalling randomly.

// File: rtl/desc_chain_dma.sv
module desc_chain_dma #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic          busy,
  output logic          irq,
  output logic [AW-1:0] done_addr,
  output logic          overrun,
  output logic          no_eop_err,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_sop,
  output logic          tx_eop,
  output logic [15:0]   tx_pkt_len
);
  localparam int SOP_B = 31;
  localparam int EOP_B = 30;
  localparam int OWN_B = 29;

  typedef enum logic [2:0] {IDLE, RD_NEXT, RD_BUF, RD_LEN, RD_FLG, MOVE, WBACK} st_t;
  st_t st;

  logic [AW-1:0] cur, nxt, bptr;
  logic [15:0]   remain;
  logic [31:0]   w3;
  logic          first;
  logic          head_wr, ack_wr, finish;

  assign busy      = (st != IDLE);
  assign head_wr   = reg_wr && !reg_sel;
  assign ack_wr    = reg_wr && reg_sel && (reg_wdata[AW-1:0] == done_addr);
  assign finish    = (st == WBACK) && (nxt == '0);
  assign tx_valid  = (st == MOVE);
  assign tx_data   = mem_rdata[{bptr[1:0], 3'b000} +: 8];
  assign tx_sop    = tx_valid && first && w3[SOP_B];
  assign tx_eop    = tx_valid && (remain == 16'd1) && w3[EOP_B];
  assign mem_rd    = (st == RD_NEXT) || (st == RD_BUF) || (st == RD_LEN) ||
                     (st == RD_FLG) || (st == MOVE);
  assign mem_wr    = (st == WBACK);
  assign mem_wdata = w3 & ~(32'd1 << OWN_B);

  always_comb begin
    case (st)
      RD_NEXT: mem_addr = cur;
      RD_BUF:  mem_addr = cur + AW'(4);
      RD_LEN:  mem_addr = cur + AW'(8);
      RD_FLG:  mem_addr = cur + AW'(12);
      WBACK:   mem_addr = cur + AW'(12);
      MOVE:    mem_addr = {bptr[AW-1:2], 2'b00};
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      cur        <= '0;
      nxt        <= '0;
      bptr       <= '0;
      remain     <= '0;
      w3         <= '0;
      first      <= 1'b0;
      irq        <= 1'b0;
      done_addr  <= '0;
      overrun    <= 1'b0;
      no_eop_err <= 1'b0;
      tx_pkt_len <= '0;
    end else begin
      if (ack_wr) irq <= 1'b0;
      if (head_wr && busy) overrun <= 1'b1;
      case (st)
        IDLE: if (head_wr) begin
          cur        <= reg_wdata[AW-1:0];
          no_eop_err <= 1'b0;
          st         <= RD_NEXT;
        end
        RD_NEXT: begin
          nxt <= mem_rdata[AW-1:0];
          st  <= RD_BUF;
        end
        RD_BUF: begin
          bptr <= mem_rdata[AW-1:0];
          st   <= RD_LEN;
        end
        RD_LEN: begin
          bptr   <= bptr + AW'(mem_rdata[31:16]);
          remain <= mem_rdata[15:0];
          st     <= RD_FLG;
        end
        RD_FLG: begin
          w3    <= mem_rdata;
          first <= 1'b1;
          if (mem_rdata[SOP_B]) tx_pkt_len <= mem_rdata[15:0];
          st <= (remain == 16'd0) ? WBACK : MOVE;
        end
        MOVE: if (tx_ready) begin
          bptr   <= bptr + AW'(1);
          remain <= remain - 16'd1;
          first  <= 1'b0;
          if (remain == 16'd1) st <= WBACK;
        end
        WBACK: begin
          if (nxt == '0) begin
            st         <= IDLE;
            done_addr  <= cur;
            irq        <= 1'b1;
            no_eop_err <= !w3[EOP_B];
          end else begin
            cur <= nxt;
            st  <= RD_NEXT;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_start_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    head_wr && !busy |=> mem_rd && mem_addr == $past(reg_wdata[AW-1:0]));

  assert_hold_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop));

  assert_finish_report_R8: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> irq && !busy && done_addr == $past(cur));

  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack_wr |=> irq);

  assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    head_wr && busy |=> overrun);

  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

// File: tb/desc_chain_dma_test.sv
`timescale 1ns/1ps
module desc_chain_dma_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        busy, irq, overrun, no_eop_err;
  logic [31:0] done_addr, mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr;
  logic        tx_valid, tx_sop, tx_eop;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic [15:0] tx_pkt_len;

  desc_chain_dma uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .busy(busy), .irq(irq), .done_addr(done_addr), .overrun(overrun), .no_eop_err(no_eop_err),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_pkt_len(tx_pkt_len));

  logic [31:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;

  typedef struct {
    int          kind;   // 1 fetch, 2 byte, 3 write-back
    logic [31:0] addr;
    logic [31:0] data;
    logic        sop, eop, last, noeop;
    logic [15:0] plen;
  } ev_t;
  ev_t q[$];

  int checks = 0, fails = 0, cycles = 0;
  logic        e_irq = 0, e_ovr = 0, e_noeop = 0;
  logic [31:0] e_done = 0;
  logic [15:0] m_plen = 0;
  logic        force_rdy = 0, ended = 0;
  logic [7:0]  lfsr = 8'hA7;

  function automatic logic [7:0] byte_at(logic [31:0] a);
    return mem[a[9:2]][{a[1:0], 3'b000} +: 8];
  endfunction

  function automatic void build(logic [31:0] head);
    logic [31:0] a, w0, w1, w2, w3, b;
    ev_t e;
    a = head;
    for (int n = 0; n < 16; n++) begin
      w0 = mem[a[9:2]]; w1 = mem[a[9:2] + 1]; w2 = mem[a[9:2] + 2]; w3 = mem[a[9:2] + 3];
      for (int k = 0; k < 4; k++) begin
        e = '{kind: 1, addr: a + 32'(4 * k), data: 0, sop: 0, eop: 0, last: 0, noeop: 0, plen: 0};
        q.push_back(e);
      end
      if (w3[31]) m_plen = w3[15:0];
      b = w1 + {16'd0, w2[31:16]};
      for (int i = 0; i < int'(w2[15:0]); i++) begin
        e = '{kind: 2, addr: b + 32'(i), data: {24'd0, byte_at(b + 32'(i))},
              sop: (i == 0) && w3[31], eop: (i == int'(w2[15:0]) - 1) && w3[30],
              last: 0, noeop: 0, plen: m_plen};
        q.push_back(e);
      end
      e = '{kind: 3, addr: a + 32'd12, data: w3 & ~32'h2000_0000, sop: 0, eop: 0,
            last: (w0 == 0), noeop: !w3[30], plen: 0};
      q.push_back(e);
      if (w0 == 0) break;
      a = w0;
    end
  endfunction

  always @(negedge clk) if (!ended) begin
    ev_t e, f;
    logic ok, was_busy, fin;
    string tag;
    checks++;
    if (q.size() == 0) begin
      ok = !busy && !tx_valid && !mem_wr && !mem_rd; tag = "R1/R8 idle";
    end else begin
      e = q[0];
      case (e.kind)
        1: begin ok = busy && mem_rd && !mem_wr && !tx_valid && mem_addr == e.addr; tag = "R2/R3/R6 fetch"; end
        2: begin ok = busy && tx_valid && !mem_wr && tx_data == e.data[7:0] && tx_sop == e.sop &&
                      tx_eop == e.eop && tx_pkt_len == e.plen; tag = "R3/R4/R5/R12 byte"; end
        default: begin ok = busy && mem_wr && !tx_valid && mem_addr == e.addr && mem_wdata == e.data;
                       tag = "R7 writeback"; end
      endcase
    end
    if (!ok) begin
      fails++;
      $display("FAIL %s t=%0t: act busy=%b v=%b d=%h sop=%b eop=%b len=%0d rd=%b wr=%b a=%h wd=%h exp kind=%0d a=%h d=%h sop=%b eop=%b len=%0d",
               tag, $time, busy, tx_valid, tx_data, tx_sop, tx_eop, tx_pkt_len, mem_rd, mem_wr,
               mem_addr, mem_wdata, (q.size() == 0) ? 0 : e.kind, e.addr, e.data, e.sop, e.eop, e.plen);
    end
    checks++;
    if (!(irq == e_irq && done_addr == e_done && overrun == e_ovr && no_eop_err == e_noeop)) begin
      fails++;
      $display("FAIL R1/R8/R9/R10/R11 status t=%0t: act irq=%b done=%h ovr=%b noeop=%b exp irq=%b done=%h ovr=%b noeop=%b",
               $time, irq, done_addr, overrun, no_eop_err, e_irq, e_done, e_ovr, e_noeop);
    end
    if (rst_n) begin
      was_busy = (q.size() != 0);
      fin = 0;
      if (was_busy && (q[0].kind != 2 || tx_ready)) begin
        f = q.pop_front();
        if (f.kind == 3 && f.last) begin
          fin = 1; e_done = f.addr - 32'd12; e_noeop = f.noeop;
        end
      end
      if (reg_wr && reg_sel && reg_wdata == done_addr) e_irq = 0;
      if (reg_wr && !reg_sel) begin
        if (was_busy) e_ovr = 1;
        else begin build(reg_wdata); e_noeop = 0; end
      end
      if (fin) e_irq = 1;
    end
  end

  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready = force_rdy | lfsr[0] | lfsr[2];
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !ended) begin
      fails++; checks++;
      $display("FAIL watchdog: act running exp finished");
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic reg_write(input logic sel, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic wait_done();
    do begin @(posedge clk); #1; end while (!(q.size() == 0 && e_irq));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  function automatic void put_desc(logic [31:0] a, logic [31:0] nx, logic [31:0] bf,
                                   logic [15:0] off, logic [15:0] len, logic [15:0] fl, logic [15:0] pl);
    mem[a[9:2]] = nx; mem[a[9:2] + 1] = bf; mem[a[9:2] + 2] = {off, len}; mem[a[9:2] + 3] = {fl, pl};
  endfunction

  initial begin
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 4; j++) mem[i][8 * j +: 8] = 8'((4 * i + j) * 7 + 1);
    // chain A: two-descriptor packet, then single-descriptor packet (R3, R5, R6)
    put_desc(32'h100, 32'h140, 32'h200, 16'd3, 16'd5, 16'hA000, 16'd12);
    put_desc(32'h140, 32'h180, 32'h240, 16'd0, 16'd7, 16'h6000, 16'd0);
    put_desc(32'h180, 32'h000, 32'h281, 16'd1, 16'd4, 16'hE000, 16'd4);
    // chain B: zero-length start descriptor (R12), last lacks end flag (R11)
    put_desc(32'h1C0, 32'h1D0, 32'h300, 16'd0, 16'd0, 16'hA000, 16'd9);
    put_desc(32'h1D0, 32'h000, 32'h300, 16'd2, 16'd3, 16'h2000, 16'd0);
    idle(3);
    rst_n = 1;
    idle(3);
    reg_write(0, 32'h100);
    // R10: head write in the final write-back cycle is ignored
    do begin @(posedge clk); #1; end while (!(q.size() == 1 && q[0].kind == 3));
    reg_wr = 1; reg_sel = 0; reg_wdata = 32'h1C0;
    @(posedge clk); #1; reg_wr = 0;
    wait_done();
    idle(2);
    reg_write(1, 32'h140);   // R9: wrong value, no effect
    idle(3);
    reg_write(1, 32'h180);   // R9: acknowledge
    idle(2);
    reg_write(0, 32'h1C0);
    idle(6);
    reg_write(0, 32'h100);   // R10: ignored mid-chain
    wait_done();
    idle(2);
    reg_write(1, 32'h1D0);
    idle(2);
    force_rdy = 1;
    reg_write(0, 32'h100);   // R11: error cleared on accepted start; R7: ownership already clear
    wait_done();
    reg_write(1, 32'h180);
    idle(4);
    ended = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule